// File: doc/BRIEF.md
# Literal-Operand Execute Stage for an 8-bit Accumulator Core

This block carries out the immediate-operand instructions of a small accumulator processor. Each accepted 16-bit instruction word is decoded, and in the cycle after acceptance the block shows four things. The first is the new working register (W). The second is the 4-bit bank-select value. The third is a 16-bit product register. The fourth is five status flags. A set of 12-bit file-select pointers is loaded through a two-word instruction. The first word of that pair selects the pointer and carries the top four literal bits. The second word carries the low byte.

The block also reports when an instruction finishes and how many cycles it costs. It raises a return-request strobe for the return-with-literal form. It raises an illegal-op strobe for words it does not recognise. Fetch, the program counter, the call stack, register-file operations and branches belong to other stages. The stage that feeds words in uses the cycle count and the return strobe to pace itself.

Top module: `lit_exec_unit`

## Requirements
- R1: After reset W, bank, product, all status flags and every file-select pointer read zero, and done, cycle count, return request and illegal are all low.
- R2: A word with high byte 0x0F sets W to W + k, where k is the low byte. The flags are status bit 0 = carry out of bit 7, bit 1 = carry out of bit 3, bit 2 = result zero, bit 3 = signed overflow and bit 4 = result bit 7.
- R3: High byte 0x08 sets W to k − W. Carry (bit 0) is set when there is no borrow (k ≥ W), and bit 1 is the same rule on the low nibbles. Bits 2, 3 and 4 follow the R2 meanings for the difference.
- R4: High bytes 0x0B (AND), 0x09 (OR) and 0x0A (XOR) combine k with W into W. They update only status bits 2 and 4, and bits 0, 1 and 3 keep their previous values.
- R5: High byte 0x0E loads W with k. High byte 0x0D loads the product register with the unsigned product W × k and leaves W alone. Neither of them changes any status flag.
- R6: High byte 0x01 with bits 7:4 equal to zero loads bank with bits 3:0 and changes nothing else. With any of bits 7:4 set, the word is illegal (R10).
- R7: High byte 0x0C loads W with k, leaves the flags unchanged, reports a cycle count of 2 and pulses the return request for one cycle.
- R8: A first word 0xEE with bits 7:6 zero opens a pair, taking the pointer index from bits 5:4 and the literal's bits 11:8 from bits 3:0. It raises no done and changes no output. The next accepted word whose top nibble is 0xF then writes {bits 11:8, its low byte} into the selected pointer, with done and a cycle count of 2.
- R9: A word whose top nibble is 0xF and that does not directly follow an open first word is a no-operation. It reports done with a cycle count of 1 and changes no state.
- R10: Any other word is illegal. It changes no state and reports done, illegal and a cycle count of 1.
- R11: Results appear exactly one cycle after the word is accepted. Every single-word instruction except R7 reports a cycle count of 1. Without an accepted word the done, return and illegal strobes stay low.
- R12: When an open pair is followed by a word whose top nibble is not 0xF, the pair is abandoned and that word executes normally. A 0xF word after it is then a no-operation and no pointer changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| instr_valid | input | 1 | Instruction word is accepted this cycle |
| instr | input | 16 | Instruction word |
| w_o | output | 8 | Working register |
| bank_o | output | 4 | Bank-select register |
| prod_o | output | 16 | Product register |
| status_o | output | 5 | Flags: 0 carry, 1 digit carry, 2 zero, 3 overflow, 4 negative |
| fsr_o | output | 48 | Four 12-bit file-select pointers, pointer i in bits 12i+11:12i |
| done_o | output | 1 | An instruction completed on the previous accepted word |
| cyc_o | output | 2 | Cycle cost of the completed instruction, zero when done is low |
| ret_req_o | output | 1 | Return must be requested |
| illegal_o | output | 1 | Unrecognised word was seen |

## Verification
Wrong internal state shows up at W, the flags or a pointer in the cycle right after the faulty word. Every output is compared after each single accepted word, so a fault is caught at the instruction that caused it rather than later. Add and subtract are swept over every literal against sixteen W values that sit on the carry, nibble and sign edges. A lost or stale open-pair state cannot be seen until the following word arrives. For that reason the open-pair flag is checked by the response to the next word: whether the pointer is written or a no-operation is reported.

// File: rtl/lit_exec_pkg.sv
package lit_exec_pkg;

  typedef enum logic [3:0] {
    OP_ADD, OP_SUB, OP_AND, OP_IOR, OP_XOR,
    OP_MOVW, OP_MUL, OP_RETW, OP_MOVB,
    OP_PAIR_HI, OP_PAIR_LO, OP_NOP, OP_ILL
  } lit_op_e;

  localparam int FLAG_C  = 0;
  localparam int FLAG_DC = 1;
  localparam int FLAG_Z  = 2;
  localparam int FLAG_OV = 3;
  localparam int FLAG_N  = 4;
  localparam int FLAG_W  = 5;

  localparam logic [7:0] OPC_ADD  = 8'h0F;
  localparam logic [7:0] OPC_AND  = 8'h0B;
  localparam logic [7:0] OPC_IOR  = 8'h09;
  localparam logic [7:0] OPC_MOVW = 8'h0E;
  localparam logic [7:0] OPC_MUL  = 8'h0D;
  localparam logic [7:0] OPC_RETW = 8'h0C;
  localparam logic [7:0] OPC_SUB  = 8'h08;
  localparam logic [7:0] OPC_XOR  = 8'h0A;
  localparam logic [7:0] OPC_MOVB = 8'h01;
  localparam logic [7:0] OPC_PAIR = 8'hEE;
  localparam logic [3:0] NIB_TAIL = 4'hF;

endpackage

// File: rtl/lit_decode.sv
module lit_decode
  import lit_exec_pkg::*;
(
  input  logic [15:0] word,
  input  logic        pair_open,
  output lit_op_e     op
);

  always_comb begin
    op = OP_ILL;
    if (word[15:12] == NIB_TAIL) begin
      op = pair_open ? OP_PAIR_LO : OP_NOP;
    end else begin
      unique case (word[15:8])
        OPC_ADD:  op = OP_ADD;
        OPC_SUB:  op = OP_SUB;
        OPC_AND:  op = OP_AND;
        OPC_IOR:  op = OP_IOR;
        OPC_XOR:  op = OP_XOR;
        OPC_MOVW: op = OP_MOVW;
        OPC_MUL:  op = OP_MUL;
        OPC_RETW: op = OP_RETW;
        OPC_MOVB: op = (word[7:4] == 4'h0) ? OP_MOVB : OP_ILL;
        OPC_PAIR: op = (word[7:6] == 2'b00) ? OP_PAIR_HI : OP_ILL;
        default:  op = OP_ILL;
      endcase
    end
  end

endmodule

// File: rtl/lit_alu.sv
module lit_alu
  import lit_exec_pkg::*;
#(
  parameter int DW = 8
) (
  input  lit_op_e             op,
  input  logic [DW-1:0]       w_in,
  input  logic [DW-1:0]       k_in,
  input  logic [FLAG_W-1:0]   flags_in,
  output logic [DW-1:0]       res,
  output logic [FLAG_W-1:0]   flags_out,
  output logic [2*DW-1:0]     prod
);

  localparam int HN = 4;

  logic [DW:0]   add_full, sub_full;
  logic [HN:0]   add_half, sub_half;
  logic          add_ov, sub_ov;

  always_comb begin
    add_full = {1'b0, w_in} + {1'b0, k_in};
    add_half = {1'b0, w_in[HN-1:0]} + {1'b0, k_in[HN-1:0]};
    sub_full = {1'b0, k_in} + {1'b0, ~w_in} + {{DW{1'b0}}, 1'b1};
    sub_half = {1'b0, k_in[HN-1:0]} + {1'b0, ~w_in[HN-1:0]} + {{HN{1'b0}}, 1'b1};
    add_ov   = (w_in[DW-1] == k_in[DW-1]) && (add_full[DW-1] != w_in[DW-1]);
    sub_ov   = (w_in[DW-1] != k_in[DW-1]) && (sub_full[DW-1] != k_in[DW-1]);
  end

  always_comb begin
    res       = w_in;
    flags_out = flags_in;
    unique case (op)
      OP_ADD: begin
        res                = add_full[DW-1:0];
        flags_out[FLAG_C]  = add_full[DW];
        flags_out[FLAG_DC] = add_half[HN];
        flags_out[FLAG_OV] = add_ov;
      end
      OP_SUB: begin
        res                = sub_full[DW-1:0];
        flags_out[FLAG_C]  = sub_full[DW];
        flags_out[FLAG_DC] = sub_half[HN];
        flags_out[FLAG_OV] = sub_ov;
      end
      OP_AND:  res = w_in & k_in;
      OP_IOR:  res = w_in | k_in;
      OP_XOR:  res = w_in ^ k_in;
      default: res = w_in;
    endcase
    if (op inside {OP_ADD, OP_SUB, OP_AND, OP_IOR, OP_XOR}) begin
      flags_out[FLAG_Z] = (res == '0);
      flags_out[FLAG_N] = res[DW-1];
    end
  end

  always_comb prod = w_in * k_in;

endmodule

// File: rtl/lit_fsr_file.sv
module lit_fsr_file #(
  parameter int SEL_W = 2,
  parameter int PW    = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ld,
  input  logic [SEL_W-1:0]          sel,
  input  logic [PW-1:0]             data,
  output logic [(1<<SEL_W)*PW-1:0]  ptrs
);

  localparam int NPTR = 1 << SEL_W;

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    logic [PW-1:0] ptr_q;
    logic          ptr_en;

    always_comb ptr_en = ld && (sel == SEL_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ptr_q <= '0;
      end else if (ptr_en) begin
        ptr_q <= data;
      end
    end

    assign ptrs[g*PW +: PW] = ptr_q;
  end

endmodule

// File: rtl/lit_exec_unit.sv
module lit_exec_unit
  import lit_exec_pkg::*;
#(
  parameter int DW     = 8,
  parameter int BANK_W = 4,
  parameter int SEL_W  = 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                instr_valid,
  input  logic [15:0]                         instr,
  output logic [DW-1:0]                       w_o,
  output logic [BANK_W-1:0]                   bank_o,
  output logic [2*DW-1:0]                     prod_o,
  output logic [FLAG_W-1:0]                   status_o,
  output logic [(1<<SEL_W)*(DW+4)-1:0]        fsr_o,
  output logic                                done_o,
  output logic [1:0]                          cyc_o,
  output logic                                ret_req_o,
  output logic                                illegal_o
);

  localparam int PTR_W = DW + 4;
  localparam int PRD_W = 2 * DW;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync_q[1];

  // architectural and pair state
  logic [DW-1:0]     w_q, w_n;
  logic [BANK_W-1:0] bank_q, bank_n;
  logic [PRD_W-1:0]  prod_q, prod_n;
  logic [FLAG_W-1:0] st_q, st_n;
  logic              open_q, open_n;
  logic [SEL_W-1:0]  psel_q, psel_n;
  logic [3:0]        phi_q, phi_n;
  logic              done_q, done_n;
  logic [1:0]        cyc_q, cyc_n;
  logic              ret_q, ret_n;
  logic              ill_q, ill_n;
  logic              ptr_ld;

  lit_op_e           op;
  logic [DW-1:0]     alu_res;
  logic [FLAG_W-1:0] alu_flags;
  logic [PRD_W-1:0]  alu_prod;
  logic [DW-1:0]     k_lit;

  assign k_lit = instr[DW-1:0];

  lit_decode u_dec (
    .word      (instr),
    .pair_open (open_q),
    .op        (op)
  );

  lit_alu #(.DW(DW)) u_alu (
    .op        (op),
    .w_in      (w_q),
    .k_in      (k_lit),
    .flags_in  (st_q),
    .res       (alu_res),
    .flags_out (alu_flags),
    .prod      (alu_prod)
  );

  lit_fsr_file #(.SEL_W(SEL_W), .PW(PTR_W)) u_ptr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .ld    (ptr_ld),
    .sel   (psel_q),
    .data  ({phi_q, k_lit}),
    .ptrs  (fsr_o)
  );

  // next state
  always_comb begin
    w_n    = w_q;
    bank_n = bank_q;
    prod_n = prod_q;
    st_n   = st_q;
    open_n = open_q;
    psel_n = psel_q;
    phi_n  = phi_q;
    done_n = 1'b0;
    cyc_n  = 2'd0;
    ret_n  = 1'b0;
    ill_n  = 1'b0;
    ptr_ld = 1'b0;
    if (instr_valid) begin
      open_n = 1'b0;
      done_n = 1'b1;
      cyc_n  = 2'd1;
      unique case (op)
        OP_ADD, OP_SUB, OP_AND, OP_IOR, OP_XOR: begin
          w_n  = alu_res;
          st_n = alu_flags;
        end
        OP_MOVW: w_n    = k_lit;
        OP_MUL:  prod_n = alu_prod;
        OP_RETW: begin
          w_n   = k_lit;
          cyc_n = 2'd2;
          ret_n = 1'b1;
        end
        OP_MOVB: bank_n = instr[BANK_W-1:0];
        OP_PAIR_HI: begin
          open_n = 1'b1;
          psel_n = instr[4 +: SEL_W];
          phi_n  = instr[3:0];
          done_n = 1'b0;
          cyc_n  = 2'd0;
        end
        OP_PAIR_LO: begin
          ptr_ld = 1'b1;
          cyc_n  = 2'd2;
        end
        OP_NOP:  cyc_n = 2'd1;
        default: ill_n = 1'b1;
      endcase
    end
  end

  // architectural registers, enabled by an accepted word
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      w_q    <= '0;
      bank_q <= '0;
      prod_q <= '0;
      st_q   <= '0;
      open_q <= 1'b0;
      psel_q <= '0;
      phi_q  <= '0;
    end else if (instr_valid) begin
      w_q    <= w_n;
      bank_q <= bank_n;
      prod_q <= prod_n;
      st_q   <= st_n;
      open_q <= open_n;
      psel_q <= psel_n;
      phi_q  <= phi_n;
    end
  end

  // report strobes, updated every cycle
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      done_q <= 1'b0;
      cyc_q  <= 2'd0;
      ret_q  <= 1'b0;
      ill_q  <= 1'b0;
    end else begin
      done_q <= done_n;
      cyc_q  <= cyc_n;
      ret_q  <= ret_n;
      ill_q  <= ill_n;
    end
  end

  assign w_o       = w_q;
  assign bank_o    = bank_q;
  assign prod_o    = prod_q;
  assign status_o  = st_q;
  assign done_o    = done_q;
  assign cyc_o     = cyc_q;
  assign ret_req_o = ret_q;
  assign illegal_o = ill_q;

endmodule

// File: rtl/lit_exec_chk.sv
module lit_exec_chk #(
  parameter int DW     = 8,
  parameter int BANK_W = 4
) (
  input logic              clk,
  input logic              rst_q,
  input logic              instr_valid,
  input logic [15:0]       instr,
  input logic [DW-1:0]     w_o,
  input logic [BANK_W-1:0] bank_o,
  input logic [2*DW-1:0]   prod_o,
  input logic [4:0]        status_o,
  input logic              done_o,
  input logic [1:0]        cyc_o,
  input logic              ret_req_o,
  input logic              illegal_o
);

  // R10
  illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    illegal_o |-> ($stable(w_o) && $stable(bank_o) && $stable(prod_o) && $stable(status_o)
                   && done_o && cyc_o == 2'd1));

  // R7
  ret_two_chk: assert property (@(posedge clk) disable iff (!rst_q)
    ret_req_o |-> (done_o && cyc_o == 2'd2));

  // R4
  logic_keep_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (instr_valid && (instr[15:8] == 8'h0B || instr[15:8] == 8'h09 || instr[15:8] == 8'h0A))
    |=> (status_o[0] == $past(status_o[0]) && status_o[1] == $past(status_o[1])
         && status_o[3] == $past(status_o[3])));

  // R5
  movw_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (instr_valid && instr[15:8] == 8'h0E)
    |=> (w_o == $past(instr[DW-1:0]) && $stable(status_o) && $stable(prod_o)));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !instr_valid |=> (!done_o && !ret_req_o && !illegal_o && cyc_o == 2'd0));

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $onehot0({ret_req_o, illegal_o}));

endmodule

bind lit_exec_unit lit_exec_chk #(.DW(DW), .BANK_W(BANK_W)) u_lit_exec_chk (
  .clk         (clk),
  .rst_q       (rst_sync_n),
  .instr_valid (instr_valid),
  .instr       (instr),
  .w_o         (w_o),
  .bank_o      (bank_o),
  .prod_o      (prod_o),
  .status_o    (status_o),
  .done_o      (done_o),
  .cyc_o       (cyc_o),
  .ret_req_o   (ret_req_o),
  .illegal_o   (illegal_o)
);

// File: tb/tb_lit_exec_unit.sv
module tb_lit_exec_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [15:0] instr = 16'h0000;
  logic [7:0]  w_o;
  logic [3:0]  bank_o;
  logic [15:0] prod_o;
  logic [4:0]  status_o;
  logic [47:0] fsr_o;
  logic        done_o;
  logic [1:0]  cyc_o;
  logic        ret_req_o;
  logic        illegal_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit summary_done = 1'b0;

  always #2 clk = ~clk;

  lit_exec_unit dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .w_o(w_o), .bank_o(bank_o), .prod_o(prod_o), .status_o(status_o),
    .fsr_o(fsr_o), .done_o(done_o), .cyc_o(cyc_o),
    .ret_req_o(ret_req_o), .illegal_o(illegal_o)
  );

  // reference state
  int m_w = 0, m_bank = 0, m_prod = 0, m_st = 0;
  int m_ptr [4] = '{0, 0, 0, 0};
  bit m_open = 0;
  int m_sel = 0, m_hi = 0;

  task automatic chk(string rq, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", rq, what, act, exp);
    end
  endtask

  function automatic int sx(int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  task automatic check_all(string rq, int e_done, int e_cyc, int e_ret, int e_ill);
    chk(rq, "w", w_o, m_w);
    chk(rq, "bank", bank_o, m_bank);
    chk(rq, "prod", prod_o, m_prod);
    chk(rq, "status", status_o, m_st);
    for (int i = 0; i < 4; i++) chk(rq, "ptr", fsr_o[i*12 +: 12], m_ptr[i]);
    chk(rq, "done", done_o, e_done);
    chk(rq, "cyc", cyc_o, e_cyc);
    chk(rq, "ret", ret_req_o, e_ret);
    chk(rq, "illegal", illegal_o, e_ill);
  endtask

  task automatic exec(input logic [15:0] word);
    int hb = word[15:8];
    int k  = word[7:0];
    int r, s, c, dc, ov;
    string rq = "R10";
    int e_done = 1, e_cyc = 1, e_ret = 0, e_ill = 0;
    bit was_open = m_open;
    m_open = 0;
    if (word[15:12] == 4'hF) begin
      if (was_open) begin rq = "R8"; m_ptr[m_sel] = m_hi * 256 + k; e_cyc = 2; end
      else rq = "R9";
    end else if (hb == 8'h0F || hb == 8'h08) begin
      if (hb == 8'h0F) begin
        rq = "R2"; s = m_w + k; c = s > 255; dc = (m_w % 16) + (k % 16) > 15;
        ov = (sx(m_w) + sx(k) > 127) || (sx(m_w) + sx(k) < -128);
      end else begin
        rq = "R3"; s = k - m_w; c = k >= m_w; dc = (k % 16) >= (m_w % 16);
        ov = (sx(k) - sx(m_w) > 127) || (sx(k) - sx(m_w) < -128);
      end
      r = s & 255; m_w = r;
      m_st = c + 2 * dc + 4 * (r == 0) + 8 * ov + 16 * (r >= 128);
    end else if (hb == 8'h0B || hb == 8'h09 || hb == 8'h0A) begin
      rq = "R4";
      r = (hb == 8'h0B) ? (m_w & k) : (hb == 8'h09) ? (m_w | k) : (m_w ^ k);
      m_w = r;
      m_st = (m_st & 11) + 4 * (r == 0) + 16 * (r >= 128);
    end else if (hb == 8'h0E) begin rq = "R5"; m_w = k;
    end else if (hb == 8'h0D) begin rq = "R5"; m_prod = m_w * k;
    end else if (hb == 8'h0C) begin rq = "R7"; m_w = k; e_cyc = 2; e_ret = 1;
    end else if (hb == 8'h01 && k < 16) begin rq = "R6"; m_bank = k;
    end else if (hb == 8'hEE && k < 64) begin
      rq = "R8"; m_open = 1; m_sel = k / 16; m_hi = k % 16; e_done = 0; e_cyc = 0;
    end else begin
      e_ill = 1;
    end
    @(negedge clk);
    instr = word;
    instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    check_all(rq, e_done, e_cyc, e_ret, e_ill);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    if (!summary_done) begin
      summary_done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
    $finish;
  end

  initial begin
    int wl [16] = '{0, 1, 8'h0F, 8'h10, 8'h3F, 8'h40, 8'h7E, 8'h7F,
                    8'h80, 8'h81, 8'hA5, 8'hC0, 8'hF0, 8'hFE, 8'hFF, 8'h5A};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check_all("R1", 0, 0, 0, 0);

    // R2 R3 sweep: every literal against edge values of W
    for (int i = 0; i < 16; i++) begin
      for (int k = 0; k < 256; k++) begin
        exec({8'h0E, 8'(wl[i])});
        exec({8'h0F, 8'(k)});
        exec({8'h0E, 8'(wl[i])});
        exec({8'h08, 8'(k)});
      end
    end

    // R4 logic ops, preceded by an add so the kept flags are mixed
    for (int i = 0; i < 16; i++) begin
      for (int k = 0; k < 256; k += 3) begin
        exec({8'h0E, 8'(wl[i])});
        exec({8'h0F, 8'(k)});
        exec({8'h0B, 8'(k ^ 8'h55)});
        exec({8'h09, 8'(k)});
        exec({8'h0A, 8'(k + 7)});
      end
    end

    // R5 multiply keeps W and flags
    for (int i = 0; i < 16; i++) begin
      for (int k = 0; k < 256; k += 5) begin
        exec({8'h0E, 8'(wl[i])});
        exec({8'h0D, 8'(k)});
      end
      exec({8'h0D, 8'hFF});
    end

    // R6 bank load and its illegal variants
    for (int b = 0; b < 16; b++) exec({8'h01, 4'h0, 4'(b)});
    exec(16'h0113);
    exec(16'h01F0);

    // R7 return with literal
    exec(16'h0F01);
    exec(16'h0C9C);
    exec(16'h0C00);

    // R8 pointer pairs, every index
    for (int p = 0; p < 4; p++) begin
      exec({8'hEE, 2'b00, 2'(p), 4'(p * 5 + 3)});
      exec({8'hF0, 8'(p * 37 + 11)});
    end
    exec(16'hEE3F);
    exec(16'hFBCD);

    // R9 orphan tail words
    exec(16'hF000);
    exec(16'hFFFF);

    // R10 illegal words
    exec(16'h0000);
    exec(16'h1234);
    exec(16'hEE40);
    exec(16'h0700);
    exec(16'hEDFF);

    // R12 abandoned pair
    exec(16'hEE15);
    exec(16'h0E77);
    exec(16'hF0AA);
    exec(16'hEE2C);
    exec(16'h0000);
    exec(16'hF011);

    // R11 idle cycles keep the strobes low
    repeat (3) @(negedge clk);
    check_all("R11", 0, 0, 0, 0);

    if (!summary_done) begin
      summary_done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
    $finish;
  end

endmodule